// File: doc/BRIEF.md
# Floating-Point Normalize, Round and Pack Unit

This block turns an unpacked floating-point result into its packed multi-word memory form and reports an arithmetic trap code. The arithmetic stage ahead of it supplies a sign, a signed unbiased exponent, a 57-bit mantissa and a precision select. The mantissa holds, from the top down: one carry position, the implied leading one, 54 fraction bits and one guard bit. The unit first normalizes the mantissa. A carry costs one right shift. Otherwise the mantissa is shifted left one place per clock until the implied bit is set. The unit then rounds by adding half of the least significant kept bit, masks the fraction to the selected precision, packs up to four 16-bit words and classifies the exponent.

The packed format is sign-magnitude with an exponent in excess-256. The two-word form keeps 22 fraction bits, the three-word form 38 and the four-word form 54. A companion combinational path unpacks packed words back into sign, exponent and mantissa, so that results can be taken round a full loop.

The control is a four-state machine. In IDLE, a start pulse captures the operands (transition IDLE->NORM). NORM stays in place while it shifts left (NORM->NORM). It moves to ROUND once the implied bit is set or after one carry right shift (NORM->ROUND). On a zero mantissa it goes straight to DONE (NORM->DONE). ROUND registers the packed words and the trap code (ROUND->DONE). DONE raises `done` for one cycle and returns (DONE->IDLE).

Top module: `fpnp_unit`

## Requirements
- R1: While reset is held and after its release, before any start, `done` is 0, all four output words are 0 and `out_trap` is 0.
- R2: A start with an all-zero `in_mant` gives four zero words and trap 0, whatever the sign and exponent. `done` is high in the cycle after the clock edge that samples start.
- R3: When the carry position (`in_mant[56]`) is set, the mantissa is shifted right once and the exponent is raised by one. `done` is high two cycles after the start edge.
- R4: When neither bit 56 nor bit 55 is set, the mantissa is shifted left one place per cycle and the exponent is lowered by one per shift, until bit 55 is set. With n shifts, `done` is high 2+n cycles after the start edge, and n is at most 55.
- R5: Rounding adds a one at `in_mant` bit 32 for two words (`in_prec`=0), bit 16 for three words (1) and bit 0 for four words (2 or 3). A carry out of the implied position raises the exponent by one and leaves the fraction field zero.
- R6: The packed layout is `w0[15]` = sign, `w0[14:6]` = low 9 bits of exponent+256, `w0[5:0]` = top 6 fraction bits, and `w1`..`w3` = the next fraction bits, most significant first. The words beyond the selected precision are zero, and `in_prec`=3 behaves as four words.
- R7: An underflow occurs when the final exponent is below -256, or equal to -256 with a zero fraction. It gives trap 3 for two words and trap 9 (octal 11) for three or four words.
- R8: An overflow occurs when the final exponent is above +255. It gives trap 2 for two words and trap 8 (octal 10) for three or four words. The words still carry the low 9 bits of the wrapped exponent.
- R9: Each accepted start produces exactly one single-cycle `done` pulse. A start while the unit is busy is ignored, and the result belongs to the first operand.
- R10: Unpacking a nonzero value gives `up_sign` = `w0[15]`, `up_exp` = `w0[14:6]`-256, and `up_mant` = {0, 1, fraction, 0}. Words beyond `up_prec` are read as zero.
- R11: Unpacking words whose exponent field and in-precision fraction are all zero gives sign 0, exponent -256 and mantissa 0. The sign bit and any words beyond the precision are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| in_sign | input | 1 | Sign of the value to pack |
| in_exp | input | 12 | Signed unbiased exponent |
| in_mant | input | 57 | Carry, implied bit, 54 fraction bits, guard bit |
| in_prec | input | 2 | 0 two words, 1 three words, 2 or 3 four words |
| done | output | 1 | One-cycle result strobe |
| out_w0 | output | 16 | Packed word 0: sign, exponent, fraction top |
| out_w1 | output | 16 | Packed word 1 |
| out_w2 | output | 16 | Packed word 2 |
| out_w3 | output | 16 | Packed word 3 |
| out_trap | output | 4 | Trap code, valid with done |
| up_w0 | input | 16 | Word 0 to unpack |
| up_w1 | input | 16 | Word 1 to unpack |
| up_w2 | input | 16 | Word 2 to unpack |
| up_w3 | input | 16 | Word 3 to unpack |
| up_prec | input | 2 | Precision of the words to unpack |
| up_sign | output | 1 | Unpacked sign |
| up_exp | output | 12 | Unpacked signed exponent |
| up_mant | output | 57 | Unpacked mantissa in the input layout |

## Verification
The time a packed result takes depends on the operand. A zero mantissa reaches `done` one cycle after the start edge. A carry or already-normalized mantissa reaches it after two cycles, and a mantissa needing n left shifts after 2+n cycles. The bench predicts that count for every operand from its own model. It counts the clock edges after start and checks both the latency and the words and trap code, sampled on the falling edge where `done` is first seen high. The unpack path is combinational, so its outputs are checked a short delay after the inputs change.

// File: rtl/fpnp_pkg.sv
package fpnp_pkg;

    localparam int WORD_W    = 16;
    localparam int WORDS_MAX = 4;
    localparam int EXPF_W    = 9;
    localparam int EXP_BIAS  = 256;
    localparam int TOP_BITS  = WORD_W - 1 - EXPF_W;
    localparam int DATA_W    = WORD_W * WORDS_MAX - 1 - EXPF_W;
    localparam int MANT_W    = DATA_W + 3;
    localparam int CARRY_POS = MANT_W - 1;
    localparam int IMPL_POS  = MANT_W - 2;
    localparam int PACK_W    = WORD_W * WORDS_MAX;
    localparam int N_PREC    = 3;
    localparam int TRAP_W    = 4;

    localparam logic [TRAP_W-1:0] TRAP_NONE    = 4'o00;
    localparam logic [TRAP_W-1:0] TRAP_STD_OVF = 4'o02;
    localparam logic [TRAP_W-1:0] TRAP_STD_UNF = 4'o03;
    localparam logic [TRAP_W-1:0] TRAP_EXT_OVF = 4'o10;
    localparam logic [TRAP_W-1:0] TRAP_EXT_UNF = 4'o11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_ROUND,
        ST_DONE
    } fpnp_state_t;

    // Fraction bits kept for precision index 0, 1, 2.
    function automatic int kept_bits(input int idx);
        if (idx == 0)      return TOP_BITS + WORD_W;
        else if (idx == 1) return TOP_BITS + 2 * WORD_W;
        else               return DATA_W;
    endfunction

    // Precision code 3 folds onto the four-word form.
    function automatic logic [1:0] prec_index(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/fpnp_round_pack.sv
module fpnp_round_pack
    import fpnp_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic                    sgn,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [MANT_W-1:0]       mant,
    input  logic [1:0]              prec,
    output logic [PACK_W-1:0]       packed_o,
    output logic [TRAP_W-1:0]       trap_o
);

    localparam logic signed [EXP_W-1:0] E_MIN = EXP_W'(-EXP_BIAS);
    localparam logic signed [EXP_W-1:0] E_MAX = EXP_W'(EXP_BIAS - 1);

    logic [MANT_W-1:0] half_tab [N_PREC];
    logic [DATA_W-1:0] mask_tab [N_PREC];

    for (genvar g = 0; g < N_PREC; g++) begin : g_prec
        localparam int KEEP = kept_bits(g);
        assign half_tab[g] = MANT_W'(1) << (DATA_W - KEEP);
        assign mask_tab[g] = {DATA_W{1'b1}} << (DATA_W - KEEP);
    end

    logic [1:0]              idx;
    logic [MANT_W-1:0]       sum;
    logic                    rnd_carry;
    logic signed [EXP_W-1:0] exp_r;
    logic [DATA_W-1:0]       frac;
    logic [EXPF_W-1:0]       exp_field;
    logic                    is_ext;
    logic                    unf;
    logic                    ovf;

    always_comb begin
        idx       = prec_index(prec);
        sum       = mant + half_tab[idx];
        rnd_carry = sum[CARRY_POS];
        exp_r     = exp_in + EXP_W'(rnd_carry);
        frac      = DATA_W'(sum >> 1) & mask_tab[idx];
        exp_field = EXPF_W'(exp_r + EXP_W'(EXP_BIAS));
        is_ext    = (idx != 2'd0);
        unf       = (exp_r < E_MIN) || ((exp_r == E_MIN) && (frac == '0));
        ovf       = (exp_r > E_MAX);

        packed_o  = {sgn, exp_field, frac};

        if (unf)      trap_o = is_ext ? TRAP_EXT_UNF : TRAP_STD_UNF;
        else if (ovf) trap_o = is_ext ? TRAP_EXT_OVF : TRAP_STD_OVF;
        else          trap_o = TRAP_NONE;
    end

endmodule

// File: rtl/fpnp_unpack.sv
module fpnp_unpack
    import fpnp_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic [PACK_W-1:0]       words,
    input  logic [1:0]              prec,
    output logic                    sgn,
    output logic signed [EXP_W-1:0] exp_o,
    output logic [MANT_W-1:0]       mant_o
);

    logic [DATA_W-1:0] mask_tab [N_PREC];

    for (genvar g = 0; g < N_PREC; g++) begin : g_prec
        localparam int KEEP = kept_bits(g);
        assign mask_tab[g] = {DATA_W{1'b1}} << (DATA_W - KEEP);
    end

    logic [EXPF_W-1:0] exp_field;
    logic [DATA_W-1:0] frac;
    logic              is_zero;

    always_comb begin
        exp_field = words[PACK_W-2 -: EXPF_W];
        frac      = words[DATA_W-1:0] & mask_tab[prec_index(prec)];
        is_zero   = (exp_field == '0) && (frac == '0);
        exp_o     = EXP_W'({1'b0, exp_field}) - EXP_W'(EXP_BIAS);
        if (is_zero) begin
            sgn    = 1'b0;
            mant_o = '0;
        end else begin
            sgn    = words[PACK_W-1];
            mant_o = {1'b0, 1'b1, frac, 1'b0};
        end
    end

endmodule

// File: rtl/fpnp_unit.sv
module fpnp_unit
    import fpnp_pkg::*;
#(
    parameter int EXP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic [1:0]              in_prec,
    output logic                    done,
    output logic [WORD_W-1:0]       out_w0,
    output logic [WORD_W-1:0]       out_w1,
    output logic [WORD_W-1:0]       out_w2,
    output logic [WORD_W-1:0]       out_w3,
    output logic [TRAP_W-1:0]       out_trap,
    input  logic [WORD_W-1:0]       up_w0,
    input  logic [WORD_W-1:0]       up_w1,
    input  logic [WORD_W-1:0]       up_w2,
    input  logic [WORD_W-1:0]       up_w3,
    input  logic [1:0]              up_prec,
    output logic                    up_sign,
    output logic signed [EXP_W-1:0] up_exp,
    output logic [MANT_W-1:0]       up_mant
);

    fpnp_state_t             state_q, state_d;
    logic                    sgn_q;
    logic signed [EXP_W-1:0] exp_q;
    logic [MANT_W-1:0]       mant_q;
    logic [1:0]              prec_q;
    logic [PACK_W-1:0]       pack_q;
    logic [TRAP_W-1:0]       trap_q;

    logic                    m_zero, m_carry, m_impl;
    logic [PACK_W-1:0]       rp_words;
    logic [TRAP_W-1:0]       rp_trap;

    assign m_zero  = (mant_q == '0);
    assign m_carry = mant_q[CARRY_POS];
    assign m_impl  = mant_q[IMPL_POS];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_NORM;
            ST_NORM: begin
                if (m_zero)                state_d = ST_DONE;
                else if (m_carry || m_impl) state_d = ST_ROUND;
                else                        state_d = ST_NORM;
            end
            ST_ROUND: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Working operand: capture and normalizing shifts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgn_q  <= 1'b0;
            exp_q  <= '0;
            mant_q <= '0;
            prec_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sgn_q  <= in_sign;
                        exp_q  <= in_exp;
                        mant_q <= in_mant;
                        prec_q <= in_prec;
                    end
                end
                ST_NORM: begin
                    if (!m_zero) begin
                        if (m_carry) begin
                            mant_q <= mant_q >> 1;
                            exp_q  <= exp_q + EXP_W'(1);
                        end else if (!m_impl) begin
                            mant_q <= mant_q << 1;
                            exp_q  <= exp_q - EXP_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    fpnp_round_pack #(.EXP_W(EXP_W)) u_round_pack (
        .sgn      (sgn_q),
        .exp_in   (exp_q),
        .mant     (mant_q),
        .prec     (prec_q),
        .packed_o (rp_words),
        .trap_o   (rp_trap)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pack_q <= '0;
            trap_q <= TRAP_NONE;
        end else begin
            unique case (state_q)
                ST_NORM: begin
                    if (m_zero) begin
                        pack_q <= '0;
                        trap_q <= TRAP_NONE;
                    end
                end
                ST_ROUND: begin
                    pack_q <= rp_words;
                    trap_q <= rp_trap;
                end
                default: ;
            endcase
        end
    end

    assign done     = (state_q == ST_DONE);
    assign out_w0   = pack_q[4*WORD_W-1 -: WORD_W];
    assign out_w1   = pack_q[3*WORD_W-1 -: WORD_W];
    assign out_w2   = pack_q[2*WORD_W-1 -: WORD_W];
    assign out_w3   = pack_q[WORD_W-1:0];
    assign out_trap = trap_q;

    fpnp_unpack #(.EXP_W(EXP_W)) u_unpack (
        .words  ({up_w0, up_w1, up_w2, up_w3}),
        .prec   (up_prec),
        .sgn    (up_sign),
        .exp_o  (up_exp),
        .mant_o (up_mant)
    );

endmodule

// File: rtl/fpnp_unit_chk.sv
module fpnp_unit_chk
    import fpnp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [1:0]        in_prec,
    input logic [MANT_W-1:0] in_mant,
    input logic [WORD_W-1:0] out_w0,
    input logic [WORD_W-1:0] out_w1,
    input logic [WORD_W-1:0] out_w2,
    input logic [WORD_W-1:0] out_w3,
    input logic [TRAP_W-1:0] out_trap
);

    logic       pending;
    logic [1:0] cap_prec;
    logic       cap_zero;
    logic [6:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            cap_prec <= '0;
            cap_zero <= 1'b0;
            wait_cnt <= '0;
        end else if (start && !pending) begin
            pending  <= 1'b1;
            cap_prec <= in_prec;
            cap_zero <= (in_mant == '0);
            wait_cnt <= '0;
        end else if (done) begin
            pending  <= 1'b0;
        end else if (pending) begin
            wait_cnt <= wait_cnt + 7'd1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) reset_quiet_chk: assert (!done && out_trap == '0);
    end

    // R9
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    norm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> wait_cnt <= 7'd57);

    // R2
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_zero) |-> (out_w0 == '0 && out_w1 == '0 && out_w2 == '0
                                && out_w3 == '0 && out_trap == TRAP_NONE));

    // R6
    two_word_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_prec == 2'd0) |-> (out_w2 == '0 && out_w3 == '0));

    // R6
    three_word_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_prec == 2'd1) |-> (out_w3 == '0));

    // R7
    std_trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_prec == 2'd0) |->
            (out_trap == TRAP_NONE || out_trap == TRAP_STD_OVF || out_trap == TRAP_STD_UNF));

    // R8
    ext_trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_prec != 2'd0) |->
            (out_trap == TRAP_NONE || out_trap == TRAP_EXT_OVF || out_trap == TRAP_EXT_UNF));

endmodule

bind fpnp_unit fpnp_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .in_prec  (in_prec),
    .in_mant  (in_mant),
    .out_w0   (out_w0),
    .out_w1   (out_w1),
    .out_w2   (out_w2),
    .out_w3   (out_w3),
    .out_trap (out_trap)
);

// File: tb/fpnp_unit_tb.sv
module fpnp_unit_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               in_sign = 1'b0;
    logic signed [11:0] in_exp = '0;
    logic [56:0]        in_mant = '0;
    logic [1:0]         in_prec = '0;
    logic               done;
    logic [15:0]        out_w0, out_w1, out_w2, out_w3;
    logic [3:0]         out_trap;
    logic [15:0]        up_w0 = '0, up_w1 = '0, up_w2 = '0, up_w3 = '0;
    logic [1:0]         up_prec = '0;
    logic               up_sign;
    logic signed [11:0] up_exp;
    logic [56:0]        up_mant;

    int n_checks = 0;
    int n_errors = 0;
    int done_seen = 0;

    always #10 clk = ~clk;

    fpnp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_sign(in_sign),
        .in_exp(in_exp), .in_mant(in_mant), .in_prec(in_prec), .done(done),
        .out_w0(out_w0), .out_w1(out_w1), .out_w2(out_w2), .out_w3(out_w3),
        .out_trap(out_trap), .up_w0(up_w0), .up_w1(up_w1), .up_w2(up_w2),
        .up_w3(up_w3), .up_prec(up_prec), .up_sign(up_sign), .up_exp(up_exp),
        .up_mant(up_mant)
    );

    always @(negedge clk) if (done) done_seen++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected packed result from the requirements
    function automatic void model(input logic s, input int e_in, input logic [56:0] m_in,
                                  input logic [1:0] p, output logic [63:0] w,
                                  output logic [3:0] t, output int lat, output int e_out);
        logic [56:0] m;
        logic [56:0] half;
        logic [53:0] msk;
        logic [53:0] d;
        int k;
        int e;
        m = m_in;
        e = e_in;
        k = (p == 2'd0) ? 22 : (p == 2'd1) ? 38 : 54;
        if (m == '0) begin
            w = '0; t = 4'd0; lat = 1; e_out = -256;
            return;
        end
        lat = 2;
        if (m[56]) begin
            m = m >> 1; e = e + 1;
        end else begin
            while (!m[55]) begin
                m = m << 1; e = e - 1; lat++;
            end
        end
        half = 57'd1 << (54 - k);
        m = m + half;
        if (m[56]) e = e + 1;
        msk = {54{1'b1}} << (54 - k);
        d = m[54:1] & msk;
        w = {s, 9'(e + 256), d};
        if (e < -256 || (e == -256 && d == '0)) t = (p == 2'd0) ? 4'o03 : 4'o11;
        else if (e > 255)                        t = (p == 2'd0) ? 4'o02 : 4'o10;
        else                                     t = 4'o00;
        e_out = e;
    endfunction

    task automatic run_op(input logic s, input int e, input logic [56:0] m,
                          input logic [1:0] p, input string req);
        logic [63:0] w_exp;
        logic [3:0]  t_exp;
        int lat_exp, e_fin, cyc;
        model(s, e, m, p, w_exp, t_exp, lat_exp, e_fin);
        @(negedge clk);
        in_sign = s; in_exp = 12'(e); in_mant = m; in_prec = p; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (cyc < 80) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) break;
        end
        check(cyc == lat_exp, req, "latency", 64'(cyc), 64'(lat_exp));
        check({out_w0, out_w1, out_w2, out_w3} == w_exp, req, "words",
              {out_w0, out_w1, out_w2, out_w3}, w_exp);
        check(out_trap == t_exp, req, "trap", 64'(out_trap), 64'(t_exp));
        // R10: round trip through the unpack path for clean nonzero results
        if (t_exp == 4'd0 && m != '0) begin
            up_w0 = out_w0; up_w1 = out_w1; up_w2 = out_w2; up_w3 = out_w3; up_prec = p;
            #1;
            check(up_sign == s && int'(up_exp) == e_fin, "R10", "round trip sign/exp",
                  {51'd0, up_sign, up_exp}, {51'd0, s, 12'(e_fin)});
        end
    endtask

    task automatic check_unpack(input logic [63:0] w, input logic [1:0] p, input string req);
        logic [53:0] msk;
        logic [53:0] d;
        logic [56:0] m_exp;
        logic s_exp;
        int e_exp;
        int k;
        k = (p == 2'd0) ? 22 : (p == 2'd1) ? 38 : 54;
        msk = {54{1'b1}} << (54 - k);
        d = w[53:0] & msk;
        e_exp = int'(w[62:54]) - 256;
        if (w[62:54] == '0 && d == '0) begin
            s_exp = 1'b0; m_exp = '0;
        end else begin
            s_exp = w[63]; m_exp = {2'b01, d, 1'b0};
        end
        up_w0 = w[63:48]; up_w1 = w[47:32]; up_w2 = w[31:16]; up_w3 = w[15:0]; up_prec = p;
        #1;
        check(up_sign == s_exp, req, "unpack sign", 64'(up_sign), 64'(s_exp));
        check(int'(up_exp) == e_exp, req, "unpack exp", 64'(up_exp), 64'(12'(e_exp)));
        check(up_mant == m_exp, req, "unpack mant", 64'(up_mant), 64'(m_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seen_before;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!done && out_trap == 0 && {out_w0, out_w1, out_w2, out_w3} == 0, "R1",
              "in reset", {59'd0, done, out_trap}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && out_trap == 0 && {out_w0, out_w1, out_w2, out_w3} == 0, "R1",
              "after reset", {59'd0, done, out_trap}, 64'd0);

        // R2: zero, sign and exponent disregarded
        run_op(1'b1, 77, 57'd0, 2'd1, "R2");
        run_op(1'b0, -300, 57'd0, 2'd0, "R2");
        // R3: carry position set
        run_op(1'b0, 10, (57'd1 << 56) | 57'h123456789AB, 2'd2, "R3");
        run_op(1'b1, -5, {57{1'b1}}, 2'd0, "R3");
        // R4: longest left normalization
        run_op(1'b0, 100, 57'd1, 2'd2, "R4");
        run_op(1'b1, 3, 57'd1 << 40, 2'd1, "R4");
        // R5: half-LSB at bit 32 rounds up for two words, not for four
        run_op(1'b0, 0, (57'd1 << 55) | (57'd1 << 32), 2'd0, "R5");
        check({out_w0, out_w1} == 32'h4000_0001, "R5", "two-word round literal",
              64'({out_w0, out_w1}), 64'h4000_0001);
        run_op(1'b0, 0, (57'd1 << 55) | (57'd1 << 32), 2'd2, "R5");
        check({out_w1, out_w2} == 32'h0000_8000, "R5", "four-word no round literal",
              64'({out_w1, out_w2}), 64'h0000_8000);
        run_op(1'b0, 20, {2'b01, {55{1'b1}}}, 2'd0, "R5");
        // R6: layout literal
        run_op(1'b1, 0, (57'd1 << 55) | (57'd1 << 54), 2'd0, "R6");
        check(out_w0 == 16'hC020, "R6", "word 0 literal", 64'(out_w0), 64'hC020);
        run_op(1'b0, 7, {2'b01, {55{1'b1}}} >> 3, 2'd3, "R6");
        // R7: underflow
        run_op(1'b0, -256, 57'd1 << 55, 2'd0, "R7");
        run_op(1'b1, -256, 57'd1 << 55, 2'd1, "R7");
        run_op(1'b0, -257, 57'h0F0F0 << 30, 2'd2, "R7");
        run_op(1'b0, -256, (57'd1 << 55) | (57'd1 << 40), 2'd0, "R7");
        // R8: overflow, including by round carry
        run_op(1'b0, 255, {2'b01, {55{1'b1}}}, 2'd0, "R8");
        run_op(1'b1, 256, 57'd1 << 55, 2'd2, "R8");
        run_op(1'b0, 255, 57'd1 << 55, 2'd1, "R8");

        // R9: start while busy is ignored
        seen_before = done_seen;
        fork
            run_op(1'b0, 100, 57'd1, 2'd2, "R9");
            begin
                repeat (6) @(negedge clk);
                in_mant = 57'd1 << 55; in_exp = 12'd5; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (10) @(negedge clk);
        check(done_seen - seen_before == 1, "R9", "done pulse count",
              64'(done_seen - seen_before), 64'd1);

        // R11: zero unpack with sign set and stray words beyond precision
        check_unpack(64'h8000_0000_ABCD_1234, 2'd0, "R11");
        check_unpack(64'h0000_0000_0000_5555, 2'd1, "R11");
        // R10 directed
        check_unpack(64'h7FFF_FFFF_FFFF_FFFF, 2'd3, "R10");
        check_unpack(64'h0001_0000_ABCD_0000, 2'd0, "R10");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [63:0] r;
            logic [56:0] m;
            int e;
            r = {$urandom, $urandom};
            m = r[56:0] >> ($urandom % 57);
            if ($urandom % 16 == 0) m = '0;
            e = int'($urandom % 700) - 350;
            run_op(r[63], e, m, 2'($urandom % 4), "R6");
        end
        for (int i = 0; i < 100; i++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            check_unpack(r, 2'($urandom % 4), "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule